// File: doc/BRIEF.md
# Fuse Row Shift Sequencer

This block runs one complete access to a single row of a serially loaded fuse array. A start pulse captures the operation: read or write, the address style, the 6-bit row pattern, the row length in bits, the short-pulse width and the programming-pulse length. The block then produces the device-side waveform on its own. It drives the row pattern, the program/verify select, a shift clock, the serial data line towards the device and an active-low strobe. It also samples the serial data returned by the device.

Two address styles are handled. In the direct style the row is selected by the parallel pattern alone. In the serial style the row's bit image, which may include address bits, is also clocked into the device before the strobe. A write clocks in the whole row and then holds the strobe low for the programming time. A read returns the sampled bits in a wide vector, with the first sampled bit at index 0. The end of every operation is marked by a one-cycle done pulse.

Top module: `fuse_row_seq`

## Requirements
- R1: After reset, strobe_n_o is high and sclk_o, sdin_o, pv_o, busy_o, done_o and every bit of rd_bits are low.
- R2: The start pulse captures row_addr onto ra_o, which holds through the whole operation. pv_o is high in every busy cycle of a write and low in every cycle of a read. pv_o is low in the done cycle.
- R3: A row_len of 0 is handled as 1 and a row_len above MAX_BITS (138) is handled as 138. L below means the handled length.
- R4: A direct-style read (op_write=0, serial_style=0) strobes before any shift-clock pulse and then gives L-1 shift-clock pulses.
- R5: A serial-style read (op_write=0, serial_style=1) first gives L shift-clock pulses that present wr_bits, bit 0 first. It then strobes and then gives L-1 further pulses.
- R6: A write (op_write=1, either style) gives L shift-clock pulses that present wr_bits, bit 0 first. It then holds strobe_n_o low for exactly prog_cyc cycles, with 0 handled as 1.
- R7: sdin_o is low whenever the strobe is active.
- R8: Each shift-clock high phase, each read strobe and each gap phase lasts short_cyc cycles (T, with 0 handled as 1). busy_o therefore lasts T(2L+1)+1 cycles for a direct read, T(4L+1)+1 for a serial read and T(2L+2)+P+1 for a write, where P is the handled prog_cyc.
- R9: For a read, rd_bits[i] is the dev_sdout value sampled after the strobe (i=0) or after the i-th later shift-clock pulse. Bits at or above L are 0, and every bit is 0 after a write. done_o is a single-cycle pulse, raised once per operation.
- R10: start is ignored while busy_o is high. The running operation keeps its address, length and timing.
- R11: The shift clock and the strobe are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| op_write | input | 1 | 1 = write row, 0 = read row |
| serial_style | input | 1 | 1 = row image clocked in before a read strobe |
| row_addr | input | 6 | Row pattern to present |
| row_len | input | 8 | Bits in the row |
| short_cyc | input | 8 | Short pulse and gap width in cycles |
| prog_cyc | input | 24 | Programming strobe length in cycles |
| wr_bits | input | 138 | Bits to clock in, bit 0 first |
| dev_sdout | input | 1 | Serial data from the device |
| ra_o | output | 6 | Row pattern to the device |
| pv_o | output | 1 | Program (1) / verify (0) select |
| strobe_n_o | output | 1 | Active-low strobe |
| sclk_o | output | 1 | Shift clock |
| sdin_o | output | 1 | Serial data to the device |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| rd_bits | output | 138 | Bits read from the row, first sample at bit 0 |

## Verification
The hardest condition to reach from the ports is the clamped edge of the row length. This is a maximum-length row, or a length above the limit, combined with a serial-style read. In that case the bit counter passes through both shift loops and the last captured index is 137. The bench sweeps row lengths 0, 1, 2, 5, 138 and 200 against every style, direction and pulse width. A device model in the bench latches the clocked-in bits and answers with their complement, so bit order and the shift-before-strobe ordering show up directly in rd_bits. A second start, carrying a different address and length, is pushed in mid-operation to show that it has no effect.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_SH_SET, S_SH_HI, S_STB_LO, S_STB_HI,
    S_RD_HI, S_RD_LO, S_PROG, S_REC, S_DONE
  } seq_state_e;
endpackage

// File: rtl/fuse_seq_timer.sv
module fuse_seq_timer #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_d;

  // A phase of N cycles loads N-1; zero behaves as one cycle.
  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = (load_val == '0) ? '0 : load_val - W'(1);
    else if (cnt_q != '0)
      cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/fuse_seq_ctrl.sv
module fuse_seq_ctrl
  import fuse_seq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             t_exp,
  input  logic             wr_q,
  input  logic             ser_q,
  input  logic [LEN_W-1:0] len_q,
  output seq_state_e       state_q,
  output seq_state_e       state_d,
  output logic             accept,
  output logic             tx_shift,
  output logic             cap,
  output logic [LEN_W-1:0] cap_idx
);
  logic [LEN_W-1:0] bitcnt_q, bitcnt_d;
  logic             last;

  assign last = (bitcnt_q == len_q - LEN_W'(1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (start) state_d = S_SETUP;
      S_SETUP:  if (t_exp) state_d = (wr_q || ser_q) ? S_SH_SET : S_STB_LO;
      S_SH_SET: if (t_exp) state_d = S_SH_HI;
      S_SH_HI:  if (t_exp) state_d = !last ? S_SH_SET : (wr_q ? S_PROG : S_STB_LO);
      S_STB_LO: if (t_exp) state_d = S_STB_HI;
      S_STB_HI: if (t_exp) state_d = last ? S_DONE : S_RD_HI;
      S_RD_HI:  if (t_exp) state_d = S_RD_LO;
      S_RD_LO:  if (t_exp) state_d = last ? S_DONE : S_RD_HI;
      S_PROG:   if (t_exp) state_d = S_REC;
      S_REC:    if (t_exp) state_d = S_DONE;
      S_DONE:   state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_comb begin
    bitcnt_d = bitcnt_q;
    if (state_q == S_DONE || (state_q == S_SH_HI && t_exp && last))
      bitcnt_d = '0;
    else if (t_exp && (state_q == S_SH_HI || state_q == S_STB_HI || state_q == S_RD_LO))
      bitcnt_d = bitcnt_q + LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      bitcnt_q <= '0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
    end
  end

  assign accept   = (state_q == S_IDLE) && start;
  assign tx_shift = (state_q == S_SH_HI) && t_exp;
  assign cap      = t_exp && (state_q == S_STB_HI || state_q == S_RD_LO);
  assign cap_idx  = bitcnt_q;
endmodule

// File: rtl/fuse_seq_shift.sv
module fuse_seq_shift #(
  parameter int MAX_BITS = 138,
  parameter int LEN_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [MAX_BITS-1:0] wr_bits,
  input  logic                shift,
  input  logic                cap,
  input  logic [LEN_W-1:0]    cap_idx,
  input  logic                bit_in,
  output logic                tx_bit,
  output logic [MAX_BITS-1:0] rd_bits
);
  logic [MAX_BITS-1:0] tx_q, rx_q, hit;

  for (genvar i = 0; i < MAX_BITS; i++) begin : g_hit
    assign hit[i] = cap && (cap_idx == LEN_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load)       tx_q <= wr_bits;
      else if (shift) tx_q <= {1'b0, tx_q[MAX_BITS-1:1]};
      if (load)       rx_q <= '0;
      else if (cap)   rx_q <= (rx_q & ~hit) | (hit & {MAX_BITS{bit_in}});
    end
  end

  assign tx_bit  = tx_q[0];
  assign rd_bits = rx_q;
endmodule

// File: rtl/fuse_row_seq.sv
module fuse_row_seq
  import fuse_seq_pkg::*;
#(
  parameter int MAX_BITS = 138,
  parameter int LEN_W    = 8,
  parameter int SHORT_W  = 8,
  parameter int PROG_W   = 24,
  parameter int ADDR_W   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                op_write,
  input  logic                serial_style,
  input  logic [ADDR_W-1:0]   row_addr,
  input  logic [LEN_W-1:0]    row_len,
  input  logic [SHORT_W-1:0]  short_cyc,
  input  logic [PROG_W-1:0]   prog_cyc,
  input  logic [MAX_BITS-1:0] wr_bits,
  input  logic                dev_sdout,
  output logic [ADDR_W-1:0]   ra_o,
  output logic                pv_o,
  output logic                strobe_n_o,
  output logic                sclk_o,
  output logic                sdin_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [MAX_BITS-1:0] rd_bits
);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_BITS);

  logic [1:0]         rst_sync;
  logic               rst_n_s;
  seq_state_e         st_q, st_d;
  logic               accept, tx_shift, cap, t_exp, tx_bit;
  logic [LEN_W-1:0]   cap_idx, len_in, len_q;
  logic               wr_q, ser_q;
  logic [SHORT_W-1:0] short_q;
  logic [PROG_W-1:0]  prog_q, t_val;

  // Reset asserts at once and leaves two clocks later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  assign len_in = (row_len == '0) ? LEN_W'(1) : ((row_len > LEN_MAX) ? LEN_MAX : row_len);

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ra_o <= '0; wr_q <= 1'b0; ser_q <= 1'b0;
      len_q <= LEN_W'(1); short_q <= '0; prog_q <= '0;
    end else if (accept) begin
      ra_o <= row_addr; wr_q <= op_write; ser_q <= serial_style;
      len_q <= len_in; short_q <= short_cyc; prog_q <= prog_cyc;
    end
  end

  always_comb begin
    if (st_d == S_PROG)      t_val = prog_q;
    else if (st_q == S_IDLE) t_val = {{(PROG_W-SHORT_W){1'b0}}, short_cyc};
    else                     t_val = {{(PROG_W-SHORT_W){1'b0}}, short_q};
  end

  fuse_seq_timer #(.W(PROG_W)) u_timer (
    .clk(clk), .rst_n(rst_n_s), .load(st_d != st_q), .load_val(t_val), .expired(t_exp)
  );

  fuse_seq_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .start(start), .t_exp(t_exp), .wr_q(wr_q), .ser_q(ser_q),
    .len_q(len_q), .state_q(st_q), .state_d(st_d), .accept(accept), .tx_shift(tx_shift),
    .cap(cap), .cap_idx(cap_idx)
  );

  fuse_seq_shift #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst_n(rst_n_s), .load(accept), .wr_bits(wr_bits), .shift(tx_shift),
    .cap(cap), .cap_idx(cap_idx), .bit_in(dev_sdout), .tx_bit(tx_bit), .rd_bits(rd_bits)
  );

  assign busy_o     = (st_q != S_IDLE);
  assign done_o     = (st_q == S_DONE);
  assign pv_o       = wr_q && busy_o && !done_o;
  assign sclk_o     = (st_q == S_SH_HI) || (st_q == S_RD_HI);
  assign strobe_n_o = !((st_q == S_STB_LO) || (st_q == S_PROG));
  assign sdin_o     = ((st_q == S_SH_SET) || (st_q == S_SH_HI)) && tx_bit;
endmodule

// File: rtl/fuse_row_seq_chk.sv
module fuse_row_seq_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              pv,
  input logic              strobe_n,
  input logic              sclk,
  input logic              sdin,
  input logic [ADDR_W-1:0] ra
);
  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk && !strobe_n));
  p_sdin_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n |-> !sdin);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_pv_low_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !pv);
  p_pv_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !done) |-> $stable(pv));
  p_ra_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ra));
  p_activity_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk || !strobe_n) |-> busy);
endmodule

bind fuse_row_seq fuse_row_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_o), .done(done_o), .pv(pv_o),
  .strobe_n(strobe_n_o), .sclk(sclk_o), .sdin(sdin_o), .ra(ra_o)
);

// File: tb/fuse_row_seq_tb.sv
module fuse_row_seq_tb;
  localparam int MB = 138;

  logic          clk, rst_n, start, op_write, serial_style;
  logic [5:0]    row_addr, ra_o;
  logic [7:0]    row_len, short_cyc;
  logic [23:0]   prog_cyc;
  logic [MB-1:0] wr_bits, rd_bits;
  logic          dev_sdout, pv_o, strobe_n_o, sclk_o, sdin_o, busy_o, done_o;

  int n_chk = 0, n_bad = 0;

  fuse_row_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_write(op_write), .serial_style(serial_style),
    .row_addr(row_addr), .row_len(row_len), .short_cyc(short_cyc), .prog_cyc(prog_cyc),
    .wr_bits(wr_bits), .dev_sdout(dev_sdout), .ra_o(ra_o), .pv_o(pv_o),
    .strobe_n_o(strobe_n_o), .sclk_o(sclk_o), .sdin_o(sdin_o), .busy_o(busy_o),
    .done_o(done_o), .rd_bits(rd_bits)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Device model: captures clocked-in bits until the strobe, then serves data.
  logic [511:0] dev_in, out_vec;
  int  dev_icnt, dev_oidx, icnt_at_stb;
  bit  strobe_seen, cur_ser;

  function automatic logic rowpat(logic [5:0] a, int i);
    return (((i * 7 + int'(a)) % 5) < 2) ^ a[i % 6];
  endfunction

  always @(posedge sclk_o) begin
    if (!strobe_seen) begin
      if (dev_icnt < 512) dev_in[dev_icnt] = sdin_o;
      dev_icnt++;
    end else dev_oidx++;
  end

  always @(negedge strobe_n_o) begin
    strobe_seen = 1'b1;
    icnt_at_stb = dev_icnt;
    dev_oidx = 0;
    for (int i = 0; i < 512; i++) out_vec[i] = cur_ser ? ~dev_in[i] : rowpat(ra_o, i);
  end

  assign dev_sdout = (dev_oidx < 512) ? out_vec[dev_oidx[8:0]] : 1'b0;

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_vec(string req, logic [MB-1:0] act, logic [MB-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(bit wr, bit ser, int len, int t, int p, logic [5:0] addr, int seed, bit poke);
    logic [MB-1:0] data, exp_rd, got_rd;
    int leff, teff, peff, cyc, stb_cyc, sclk_cyc, pulses, dones, bad_pv, bad_ra, bad_sd, bad_in;
    int exp_cyc, exp_pulses;
    bit prev_sclk;
    leff = (len == 0) ? 1 : ((len > MB) ? MB : len);  // R3
    teff = (t == 0) ? 1 : t;
    peff = (p == 0) ? 1 : p;
    for (int i = 0; i < MB; i++) data[i] = ((i * 13 + seed * 5) % 7) > 2;
    dev_in = '0; out_vec = '0; dev_icnt = 0; dev_oidx = 0;
    strobe_seen = 1'b0; icnt_at_stb = -1; cur_ser = ser;
    cyc = 0; stb_cyc = 0; sclk_cyc = 0; pulses = 0; dones = 0;
    bad_pv = 0; bad_ra = 0; bad_sd = 0; bad_in = 0; prev_sclk = 1'b0; got_rd = '0;
    @(negedge clk);
    op_write = wr; serial_style = ser; row_addr = addr; row_len = 8'(len);
    short_cyc = 8'(t); prog_cyc = 24'(p); wr_bits = data; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy_o && cyc < 20000) begin
      cyc++;
      if (!strobe_n_o) stb_cyc++;
      if (sclk_o) begin
        sclk_cyc++;
        if (!prev_sclk) pulses++;
      end
      prev_sclk = sclk_o;
      if (done_o) begin
        dones++;
        if (pv_o) bad_pv++;
        got_rd = rd_bits;
      end else if (pv_o !== wr) bad_pv++;
      if (ra_o !== addr) bad_ra++;
      if (!strobe_n_o && sdin_o) bad_sd++;
      if (poke && cyc == 2) begin  // R10: second start while busy
        start = 1'b1; row_addr = addr ^ 6'h3f; row_len = 8'd1; short_cyc = 8'd1;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    if (wr)       exp_cyc = teff * (2 * leff + 2) + peff + 1;
    else if (ser) exp_cyc = teff * (4 * leff + 1) + 1;
    else          exp_cyc = teff * (2 * leff + 1) + 1;
    exp_pulses = wr ? leff : (ser ? 2 * leff - 1 : leff - 1);
    exp_rd = '0;
    if (!wr) for (int i = 0; i < leff; i++) exp_rd[i] = ser ? ~data[i] : rowpat(addr, i);
    chk(poke ? "R10 busy cycles with extra start" : "R8 busy cycles", cyc, exp_cyc);
    chk("R8 sclk pulse count", pulses, exp_pulses);
    chk("R8 sclk high cycles", sclk_cyc, exp_pulses * teff);
    chk(wr ? "R6 strobe low cycles" : "R8 strobe low cycles", stb_cyc, wr ? peff : teff);
    chk(ser ? "R5 bits before strobe" : (wr ? "R6 bits before strobe" : "R4 bits before strobe"),
        icnt_at_stb, (wr || ser) ? leff : 0);
    if (wr || ser) begin
      for (int i = 0; i < leff; i++) if (dev_in[i] !== data[i]) bad_in++;
      chk(wr ? "R6 shifted data order" : "R5 shifted data order", bad_in, 0);
    end
    chk("R2 pv level", bad_pv, 0);
    chk("R2 ra held", bad_ra, 0);
    chk("R7 sdin low at strobe", bad_sd, 0);
    chk("R9 single done", dones, 1);
    chk_vec("R9 read data", got_rd, exp_rd);
    chk_vec("R9 read data held", rd_bits, exp_rd);
  endtask

  initial begin
    int lens[6];
    int ts[3];
    lens = '{0, 1, 2, 5, 138, 200};
    ts = '{0, 2, 3};
    rst_n = 1'b0; start = 1'b0; op_write = 1'b0; serial_style = 1'b0;
    row_addr = '0; row_len = '0; short_cyc = '0; prog_cyc = '0; wr_bits = '0;
    repeat (3) @(negedge clk);
    chk("R1 strobe_n", strobe_n_o, 1);
    chk("R1 sclk", sclk_o, 0);
    chk("R1 sdin", sdin_o, 0);
    chk("R1 pv", pv_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk_vec("R1 rd_bits", rd_bits, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < 2; w++)
        for (int li = 0; li < 6; li++)
          for (int ti = 0; ti < 3; ti++)
            run_op(w[0], s[0], lens[li], ts[ti], (ti == 1) ? 0 : 9,
                   6'(li * 11 + ti * 5 + s * 3 + w), li + ti + s + w, 1'b0);
    run_op(1'b0, 1'b1, 5, 2, 4, 6'h15, 3, 1'b1);
    run_op(1'b1, 1'b0, 4, 1, 7, 6'h2a, 5, 1'b1);
    run_op(1'b0, 1'b0, 6, 3, 1, 6'h07, 1, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule